// File: doc/BRIEF.md
# Watchdog Reset and Clock-Gate Controller

This block sits beside a clock synthesizer and decides, cycle by cycle, which clock outputs may toggle. It also owns one shared pin whose job is fixed by a strap sampled while reset is held. With the strap high, the pin is an open-drain, active-low reset output. A watchdog timer drives it low for a fixed number of reference-clock cycles when it expires. With the strap low, the pin becomes an active-low power-down input that stops every clock output.

Each clock output has its own run bit, where 1 means running and 0 means stopped. A global tristate bit overrides all of the run bits. The block merges the run bits, the tristate bit and the synchronized power-down level into one registered gate per output. One index, normally the free-running PCI clock, is only an ordinary member of this vector and follows its own bit. The open-drain pin is modelled as an output enable that is high only while the pin is pulled low.

Top module: `clkgate_wdt_ctrl`

## Requirements
- R1: The pin role `mode_o` copies `mode_strap_i` while `rst` is high and holds that value after reset; 1 selects the reset-output role, 0 selects the power-down role. Strap changes after reset have no effect.
- R2: After reset all run bits are 1 and tristate is 0, so `gate_o` is all ones. `hiz_o` is 0 and `pin_oe_o` is 0.
- R3: A write with `cfg_we_i` loads `cfg_en_i` and `cfg_tri_i`. Two clock edges later, `gate_o[i]` is 1 exactly when run bit i is 1, tristate is 0 and power-down is inactive.
- R4: While tristate is 1, `hiz_o` is 1 and every bit of `gate_o` is 0, whatever the run bits hold.
- R5: The output at index `FREE_IDX` (bit 6 in the bench) is gated only by its own run bit, tristate and power-down. It runs alone when only its bit is set, and stops alone when only its bit is clear.
- R6: In the power-down role, a low on `pin_in_i` clears all of `gate_o` on the third clock edge after it is applied, through a two-stage synchronizer and the gate register. A high releases the gates again. `pin_oe_o` is never asserted in this role.
- R7: In the reset-output role, the level of `pin_in_i` has no effect on `gate_o`.
- R8: In the reset-output role, with `wdt_en_i` high and no kick, `pin_oe_o` rises on the `WDT_CYCLES`-th clock edge after enabling.
- R9: Each reset pulse keeps `pin_oe_o` high for exactly `PULSE_CYCLES` cycles. A kick during the pulse neither shortens it nor extends it.
- R10: A kick restarts the watchdog count. Kicks spaced closer than `WDT_CYCLES` never produce a pulse, and with `wdt_en_i` low no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset; the strap is sampled while it is high |
| mode_strap_i | input | 1 | Pin-role strap: 1 selects reset output, 0 selects power-down input |
| wdt_en_i | input | 1 | Enables the watchdog count |
| wdt_kick_i | input | 1 | Restarts the watchdog count |
| pin_in_i | input | 1 | Sensed level of the shared pin |
| cfg_we_i | input | 1 | Loads the run bits and the tristate bit |
| cfg_en_i | input | N_OUT | Per-output run bits (1 = run) |
| cfg_tri_i | input | 1 | Global tristate bit (1 = float all outputs) |
| gate_o | output | N_OUT | Registered per-output clock gates (1 = toggle) |
| hiz_o | output | 1 | Global tristate control |
| pin_oe_o | output | 1 | Open-drain pull-down enable for the shared pin |
| mode_o | output | 1 | Latched pin role |

## Verification
The bench counts the edges from enabling the watchdog to the pulse. A counter that is off by one gives a delay one cycle short or long. It also measures the pulse width while a kick arrives in the middle of the pulse; a design that lets the kick restart or cut off the pulse reports a wrong width. It samples the gates on the second and third edges after the power-down pin falls, which exposes a missing or extra synchronizer stage. It changes the strap after reset, which catches a role that is not truly latched. Tristate entries with every run bit set show whether tristate really overrides the run bits, and a single-bit entry at the free-running index shows whether that output is tied to its neighbours.

// File: rtl/clkgate_wdt_pkg.sv
package clkgate_wdt_pkg;
  typedef enum logic {
    ROLE_PWRDN = 1'b0,
    ROLE_RESET = 1'b1
  } pin_role_e;
endpackage

// File: rtl/cgw_sync2.sv
module cgw_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic s1_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= RST_VAL;
      q_o  <= RST_VAL;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/cgw_watchdog.sv
module cgw_watchdog #(
  parameter int WDT_CYCLES   = 100000,
  parameter int PULSE_CYCLES = 57272
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic kick_i,
  output logic pulse_o
);
  localparam int CW = $clog2(WDT_CYCLES + 1);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(WDT_CYCLES - 1);
  localparam logic [PW-1:0] PLS_LAST = PW'(PULSE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pcnt_q  <= '0;
      pulse_o <= 1'b0;
    end else if (pulse_o) begin
      // pulse runs to completion; kicks are not looked at here
      cnt_q <= '0;
      if (pcnt_q == PLS_LAST) begin
        pulse_o <= 1'b0;
        pcnt_q  <= '0;
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end else if (!arm_i || kick_i) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q   <= '0;
      pulse_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cgw_gate_merge.sv
module cgw_gate_merge #(
  parameter int N_OUT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] en_i,
  input  logic             tri_i,
  input  logic             stop_i,
  output logic [N_OUT-1:0] gate_o,
  output logic             hiz_o
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) gate_o[g] <= 1'b1;
      else     gate_o[g] <= en_i[g] & ~tri_i & ~stop_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hiz_o <= 1'b0;
    else     hiz_o <= tri_i;
  end
endmodule

// File: rtl/clkgate_wdt_ctrl.sv
module clkgate_wdt_ctrl
  import clkgate_wdt_pkg::*;
#(
  parameter int N_OUT        = 16,
  parameter int FREE_IDX     = 6,
  parameter int WDT_CYCLES   = 100000,
  parameter int PULSE_CYCLES = 57272
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_strap_i,
  input  logic             wdt_en_i,
  input  logic             wdt_kick_i,
  input  logic             pin_in_i,
  input  logic             cfg_we_i,
  input  logic [N_OUT-1:0] cfg_en_i,
  input  logic             cfg_tri_i,
  output logic [N_OUT-1:0] gate_o,
  output logic             hiz_o,
  output logic             pin_oe_o,
  output logic             mode_o
);
  pin_role_e        role_q;
  logic [N_OUT-1:0] en_q;
  logic             tri_q;
  logic             pin_sync;
  logic             pd_stop;
  logic             wdt_arm;
  logic             wdt_pulse;

  // role strap follows the pin while reset is held, frozen afterwards
  always_ff @(posedge clk) begin
    if (rst) role_q <= pin_role_e'(mode_strap_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '1;
      tri_q <= 1'b0;
    end else if (cfg_we_i) begin
      en_q  <= cfg_en_i;
      tri_q <= cfg_tri_i;
    end
  end

  cgw_sync2 #(.RST_VAL(1'b1)) u_pin_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_in_i),
    .q_o (pin_sync)
  );

  assign pd_stop = (role_q == ROLE_PWRDN) && !pin_sync;
  assign wdt_arm = (role_q == ROLE_RESET) && wdt_en_i;

  cgw_watchdog #(
    .WDT_CYCLES   (WDT_CYCLES),
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_wdt (
    .clk     (clk),
    .rst     (rst),
    .arm_i   (wdt_arm),
    .kick_i  (wdt_kick_i),
    .pulse_o (wdt_pulse)
  );

  cgw_gate_merge #(.N_OUT(N_OUT)) u_merge (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_q),
    .tri_i  (tri_q),
    .stop_i (pd_stop),
    .gate_o (gate_o),
    .hiz_o  (hiz_o)
  );

  assign pin_oe_o = wdt_pulse;
  assign mode_o   = role_q;
endmodule

// File: rtl/clkgate_wdt_ctrl_chk.sv
module clkgate_wdt_ctrl_chk #(
  parameter int N_OUT        = 16,
  parameter int PULSE_CYCLES = 57272
) (
  input logic             clk,
  input logic             rst,
  input logic             wdt_en_i,
  input logic [N_OUT-1:0] en_q,
  input logic [N_OUT-1:0] gate_o,
  input logic             hiz_o,
  input logic             pin_oe_o,
  input logic             mode_o
);
  int hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)           hi_cnt <= 0;
    else if (pin_oe_o) hi_cnt <= hi_cnt + 1;
    else               hi_cnt <= 0;
  end

  a_r1_role_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(mode_o));

  a_r6_no_drive_in_pd_role: assert property (@(posedge clk) disable iff (rst)
    pin_oe_o |-> mode_o);

  a_r4_tristate_stops_all: assert property (@(posedge clk) disable iff (rst)
    hiz_o |-> (gate_o == '0));

  a_r3_gate_needs_run_bit: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((gate_o & ~$past(en_q)) == '0));

  a_r10_fire_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_oe_o) |-> $past(wdt_en_i));

  a_r9_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_oe_o) |-> (hi_cnt == PULSE_CYCLES));

  a_r9_pulse_not_long: assert property (@(posedge clk) disable iff (rst)
    pin_oe_o |-> (hi_cnt < PULSE_CYCLES));
endmodule

bind clkgate_wdt_ctrl clkgate_wdt_ctrl_chk #(
  .N_OUT        (N_OUT),
  .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wdt_en_i (wdt_en_i),
  .en_q     (en_q),
  .gate_o   (gate_o),
  .hiz_o    (hiz_o),
  .pin_oe_o (pin_oe_o),
  .mode_o   (mode_o)
);

// File: tb/clkgate_wdt_ctrl_tb.sv
`timescale 1ns/1ps
module clkgate_wdt_ctrl_tb;
  localparam int N   = 8;
  localparam int WDT = 12;
  localparam int PLS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap = 1'b1, wen = 1'b0, kick = 1'b0, pin = 1'b1;
  logic we = 1'b0, tri_b = 1'b0;
  logic [N-1:0] en = '1;
  logic [N-1:0] gate;
  logic hiz, oe, mode;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  clkgate_wdt_ctrl #(
    .N_OUT(N), .FREE_IDX(6), .WDT_CYCLES(WDT), .PULSE_CYCLES(PLS)
  ) u_dut (
    .clk(clk), .rst(rst), .mode_strap_i(strap), .wdt_en_i(wen),
    .wdt_kick_i(kick), .pin_in_i(pin), .cfg_we_i(we), .cfg_en_i(en),
    .cfg_tri_i(tri_b), .gate_o(gate), .hiz_o(hiz), .pin_oe_o(oe),
    .mode_o(mode)
  );

  // {run bits, tristate, expected gates}; free-running output is bit 6
  localparam logic [16:0] VEC [7] = '{
    {8'hFF, 1'b0, 8'hFF},
    {8'hA5, 1'b0, 8'hA5},
    {8'hFF, 1'b1, 8'h00},
    {8'h40, 1'b0, 8'h40},
    {8'hBF, 1'b0, 8'hBF},
    {8'h00, 1'b1, 8'h00},
    {8'h3C, 1'b0, 8'h3C}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst = 1'b1; strap = s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, w;
    do_reset(1'b1);
    @(negedge clk);
    chk("R2 gates", gate, 8'hFF);
    chk("R2 hiz", hiz, 0);
    chk("R2 oe", oe, 0);
    chk("R1 mode", mode, 1);

    foreach (VEC[k]) begin
      @(negedge clk);
      en = VEC[k][16:9]; tri_b = VEC[k][8]; we = 1'b1;
      @(negedge clk); we = 1'b0;
      @(negedge clk);
      chk((k == 3 || k == 4) ? "R5 free idx" : "R3 gates", gate, VEC[k][7:0]);
      chk("R4 hiz", hiz, VEC[k][8]);
    end

    // R7: pin level ignored in reset role
    pin = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 pin ignored", gate, 8'h3C);
    pin = 1'b1;
    strap = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 strap after reset", mode, 1);

    // R10: disabled watchdog never fires
    n = 0;
    repeat (40) begin @(negedge clk); if (oe) n++; end
    chk("R10 disabled", n, 0);

    // R8/R9: delay and width
    wen = 1'b1; n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!oe && n < 100);
    chk("R8 delay", n, WDT);
    w = 0;
    while (oe && w < 100) begin w++; @(negedge clk); end
    chk("R9 width", w, PLS);

    // R10: frequent kicks keep it quiet
    n = 0;
    for (int i = 0; i < 48; i++) begin
      kick = (i % 6 == 0);
      @(negedge clk);
      if (oe) n++;
    end
    kick = 1'b0;
    chk("R10 kicked", n, 0);

    // R9: kick inside pulse is ignored
    n = 0;
    while (!oe && n < 100) begin n++; @(negedge clk); end
    w = 0;
    while (oe && w < 100) begin
      w++;
      kick = (w == 2);
      @(negedge clk);
    end
    kick = 1'b0;
    chk("R9 width with kick", w, PLS);
    wen = 1'b0;

    // R6: power-down role
    do_reset(1'b0);
    strap = 1'b1;
    @(negedge clk);
    chk("R1 pd role", mode, 0);
    pin = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R6 two edges", gate, 8'hFF);
    @(posedge clk); @(negedge clk);
    chk("R6 third edge", gate, 8'h00);
    wen = 1'b1; n = 0;
    repeat (40) begin @(negedge clk); if (oe) n++; end
    chk("R6 no drive", n, 0);
    pin = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 release", gate, 8'hFF);
    wen = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule